// File: doc/BRIEF.md
# Embedded-Clock Frame Deserializer With Lock

This block turns a recovered serial bit stream back into parallel payload words. Each frame on the line is 28 bits long. A high marker bit opens the frame and a low marker bit closes it. Between the markers the frame carries a 24-bit payload, an integrity bit and a balance bit. Bits arrive one per clock cycle in which the bit-rate enable is high. The block finds the frame alignment by hunting for the marker pair. After several consecutive confirmations it raises a lock flag, and it then delivers one payload word per frame with a one-cycle strobe.

Once locked, every frame boundary is checked again. A single frame whose markers are wrong drops lock, and the block goes straight back to hunting through arbitrary data. When the balance bit is set, the payload was sent inverted, and the block restores it. The integrity bit gives even parity over the payload as transmitted; a mismatch raises a one-cycle error pulse. An output enable and an active-low powerdown input gate the data, strobe and error outputs, but the lock flag always shows the true lock state. Powerdown also clears all alignment state.

Top module: `ecf_deser`

## Requirements
- R1: Line order within a frame: line bit 0 is the high marker. Line bits 1 to 24 are the payload, most significant bit first. Line bit 25 is the integrity bit, line bit 26 is the balance bit, and line bit 27 is the low marker (0).
- R2: While unlocked, a 28-bit window whose first bit is 1 and whose last bit is 0 becomes an alignment candidate. The lock flag rises at the last bit of the 4th consecutive frame with correct markers at that alignment. That frame is the first one delivered.
- R3: While locked, a frame whose markers are wrong clears the lock flag in the cycle after its last bit, and no strobe is given for that frame.
- R4: After lock is lost, the search restarts on its own, and lock is regained after 4 further well-formed frames.
- R5: When the balance bit is 1, the output word is the bitwise inverse of the received payload bits; when it is 0, the payload is passed unchanged.
- R6: If the XOR of the 24 received payload bits and the integrity bit is 1, the error output pulses for one cycle together with the strobe. The word is still delivered and lock is kept.
- R7: While locked, the strobe pulses for exactly one clock cycle per frame, in the cycle after the frame's last bit, together with the updated word. The strobe is never high while the lock flag is low.
- R8: With the output enable low, the word output reads 0 and the strobe and error outputs stay low, while the lock flag still reports lock. Frames received during that time still update the held word.
- R9: With the powerdown input low, lock and alignment are cleared and the outputs read 0. After release, 4 well-formed frames are needed before data is delivered again.
- R10: The serial input has no effect in cycles where the bit enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-rate enable: one line bit is taken per high cycle |
| bit_in | input | 1 | Serial line bit |
| out_en | input | 1 | Output enable for word, strobe and error |
| pd_n | input | 1 | Powerdown, active low |
| word_o | output | 24 | Restored payload word |
| word_stb | output | 1 | One-cycle frame-valid strobe |
| locked | output | 1 | Lock flag |
| parity_err | output | 1 | One-cycle integrity error pulse |

## Verification
A wrong alignment counter or confirmation count shows at the ports as a lock flag that rises one or more frames early or late. It is visible at the 28th enabled bit of the affected frame. A wrong tap in the frame window corrupts the word or the parity pulse on the very first delivered frame, because the bench uses non-symmetric payloads with and without inversion. A resynchronization fault shows as a missing or stuck lock flag within one frame of the broken marker or of the powerdown release.

// File: rtl/ecf_deser.sv
module ecf_deser #(
  parameter int FRAME   = 28,
  parameter int PAYLOAD = 24,
  parameter int ACQ     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               bit_in,
  input  logic               out_en,
  input  logic               pd_n,
  output logic [PAYLOAD-1:0] word_o,
  output logic               word_stb,
  output logic               locked,
  output logic               parity_err
);
  localparam int PW = $clog2(FRAME);
  localparam int HW = $clog2(ACQ + 1);

  logic [FRAME-1:0]   sh;
  logic [PW-1:0]      pos;
  logic [HW-1:0]      hits;
  logic               track, lock_q, stb_q, err_q;
  logic [PAYLOAD-1:0] word_q;

  wire [FRAME-1:0]   win      = {sh[FRAME-2:0], bit_in};
  wire               mark_ok  = win[FRAME-1] & ~win[0];
  wire [PAYLOAD-1:0] tx       = win[FRAME-2 -: PAYLOAD];
  wire               par_bit  = win[2];
  wire               bal_bit  = win[1];
  wire               boundary = (pos == PW'(FRAME - 1));
  wire               active   = out_en & pd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; pos <= '0; hits <= '0; track <= 1'b0; lock_q <= 1'b0;
      stb_q <= 1'b0; err_q <= 1'b0; word_q <= '0;
    end else begin
      stb_q <= 1'b0;
      err_q <= 1'b0;
      if (!pd_n) begin
        sh <= '0; pos <= '0; hits <= '0; track <= 1'b0; lock_q <= 1'b0;
        word_q <= '0;
      end else if (bit_en) begin
        sh <= win;
        if (!track) begin
          if (mark_ok) begin
            track <= 1'b1;
            hits  <= HW'(1);
            pos   <= '0;
          end
        end else begin
          pos <= boundary ? '0 : pos + 1'b1;
          if (boundary) begin
            if (mark_ok) begin
              if (lock_q || hits == HW'(ACQ - 1)) begin
                lock_q <= 1'b1;
                word_q <= bal_bit ? ~tx : tx;
                stb_q  <= 1'b1;
                err_q  <= ^{tx, par_bit};
              end
              if (!lock_q) hits <= hits + 1'b1;
            end else begin
              lock_q <= 1'b0;
              track  <= 1'b0;
              hits   <= '0;
            end
          end
        end
      end
    end
  end

  assign word_o     = active ? word_q : '0;
  assign word_stb   = active & stb_q;
  assign parity_err = active & err_q;
  assign locked     = lock_q;

  assert_stb_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> locked);
  assert_err_with_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> word_stb);
  assert_pd_clears_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !locked);
  assert_idle_holds_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && pd_n) |=> $stable(locked));
  assert_lock_rise_delivers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(locked) && active) |-> word_stb);
endmodule

// File: tb/ecf_deser_tb.sv
module ecf_deser_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0, out_en = 1'b1, pd_n = 1'b1;
  logic [23:0] word_o;
  logic word_stb, locked, parity_err;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  ecf_deser dut_i (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .out_en(out_en), .pd_n(pd_n), .word_o(word_o), .word_stb(word_stb),
    .locked(locked), .parity_err(parity_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Sends one frame; after return the outputs reflect its last bit.
  task automatic send_frame(input logic [23:0] p, input logic bal, input logic bad_par,
                            input logic bad_mark);
    logic [23:0] tx;
    logic [27:0] f;
    tx = bal ? ~p : p;
    f[27] = bad_mark ? 1'b0 : 1'b1;
    f[26:3] = tx;
    f[2] = (^tx) ^ bad_par;
    f[1] = bal;
    f[0] = 1'b0;
    for (int i = 27; i >= 0; i--) begin
      @(negedge clk); bit_in = f[i]; bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0; bit_in = ~f[i];
      if (i != 0) begin
        @(negedge clk);
      end
    end
  endtask

  task automatic idle_tick;
    @(negedge clk);
  endtask

  task automatic acquire(input string req);
    for (int k = 0; k < 3; k++) begin
      send_frame(24'h0, 1'b0, 1'b0, 1'b0);
      chk({req, " no early lock"}, {31'd0, locked}, 32'd0);
      chk({req, " no early stb"}, {31'd0, word_stb}, 32'd0);
    end
    send_frame(24'h0, 1'b0, 1'b0, 1'b0);
    chk({req, " lock on 4th"}, {31'd0, locked}, 32'd1);
    chk({req, " stb on 4th"}, {31'd0, word_stb}, 32'd1);
  endtask

  initial begin
    logic [23:0] pats [6];
    pats = '{24'hA5C31E, 24'h000001, 24'h800000, 24'h123456, 24'hFFFFFE, 24'h5A0F0F};
    repeat (3) @(negedge clk);
    chk("reset lock", {31'd0, locked}, 32'd0);
    chk("reset word", {8'd0, word_o}, 32'd0);
    rst_n = 1'b1;
    repeat (30) begin
      @(negedge clk); bit_in = ~bit_in;
    end
    chk("R10 idle toggles ignored", {31'd0, locked}, 32'd0);
    acquire("R2");
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 6; k++) begin
        send_frame(pats[k], b[0], 1'b0, 1'b0);
        chk(b ? "R5 inverted word" : "R1 plain word", {8'd0, word_o}, {8'd0, pats[k]});
        chk("R7 stb", {31'd0, word_stb}, 32'd1);
        chk("R6 no err", {31'd0, parity_err}, 32'd0);
        idle_tick();
        chk("R7 stb one cycle", {31'd0, word_stb}, 32'd0);
      end
    send_frame(24'h3C3C3C, 1'b1, 1'b1, 1'b0);
    chk("R6 err pulse", {31'd0, parity_err}, 32'd1);
    chk("R6 word kept", {8'd0, word_o}, 32'h3C3C3C);
    chk("R6 lock kept", {31'd0, locked}, 32'd1);
    idle_tick();
    chk("R6 err one cycle", {31'd0, parity_err}, 32'd0);
    out_en = 1'b0;
    send_frame(24'h00BEEF, 1'b0, 1'b1, 1'b0);
    chk("R8 word gated", {8'd0, word_o}, 32'd0);
    chk("R8 stb gated", {31'd0, word_stb}, 32'd0);
    chk("R8 err gated", {31'd0, parity_err}, 32'd0);
    chk("R8 lock visible", {31'd0, locked}, 32'd1);
    out_en = 1'b1;
    idle_tick();
    chk("R8 captured while off", {8'd0, word_o}, 32'h00BEEF);
    send_frame(24'h0, 1'b0, 1'b0, 1'b1);
    chk("R3 lock dropped", {31'd0, locked}, 32'd0);
    chk("R3 no stb", {31'd0, word_stb}, 32'd0);
    acquire("R4");
    send_frame(24'h0F1E2D, 1'b0, 1'b0, 1'b0);
    chk("R4 data after relock", {8'd0, word_o}, 32'h0F1E2D);
    pd_n = 1'b0;
    idle_tick(); idle_tick();
    chk("R9 lock cleared", {31'd0, locked}, 32'd0);
    chk("R9 word off", {8'd0, word_o}, 32'd0);
    pd_n = 1'b1;
    acquire("R9");
    send_frame(24'hC0FFEE, 1'b1, 1'b0, 1'b0);
    chk("R9 R5 data after wake", {8'd0, word_o}, 32'hC0FFEE);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule